// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array with Bidirectional Pins

This block is a combinational logic array whose behaviour is set entirely by a bank of configuration bits. Eight dedicated inputs and ten bidirectional pins form eighteen logic variables. Each variable can enter every product term as itself, as its inverse, or not at all. Thirty-two general product terms feed a fully shared sum plane, so any term may reach any group of the ten outputs. Each output then has a selectable inversion. Ten further product terms, one per pin, decide when that pin is driven.

Configuration is loaded one row per clock through an address, data and write-enable port. Reset returns every configuration bit to 1, which is the "all links intact" state. After that, the outputs follow the inputs and the current configuration with no clock in the path. Each pin is modelled as three signals: a value out, an enable out, and the level seen on the pin, which comes back in. That returned level is a variable of the array whether or not the pin is being driven.

Top module: `pla_core`

## Requirements
- R1: After reset every configuration bit is 1. Every product term then holds both literals of each variable and is false, so `pin_oe` and `pin_out` are all zero.
- R2: A write with `cfg_we` high takes effect at that clock edge. Addresses 0 to 31 hold the literal rows of logic terms 0 to 31. Addresses 32 to 41 hold the enable-term rows for pins 0 to 9. Addresses 42 to 73 hold the sum row of logic term 0 to 31. Address 74 holds the inversion row.
- R3: In a literal row, bit 2v set keeps the true literal of variable v and bit 2v+1 set keeps its inverse. Variables 0 to 7 are `ded_in[7:0]` and variables 8 to 17 are `pin_in[9:0]`. A cleared bit removes that literal. A term is true when every kept literal is true.
- R4: A term that keeps both the true and the inverse literal of the same variable is false for every input value.
- R5: Bit j of a sum row connects that logic term to output j. Output j's sum is the OR of all connected logic terms that are true, and one term may feed any number of outputs.
- R6: Bit j of the inversion row set passes sum j to `pin_out[j]` unchanged. Cleared, it passes the inverse of sum j.
- R7: `pin_oe[j]` equals enable term j.
- R8: `pin_in` takes part in every term whether or not the pin is enabled.
- R9: Writes to addresses above 74 change nothing. Data bits above bit 9 are ignored for sum rows and the inversion row.
- R10: With no write, outputs change only when `ded_in` or `pin_in` change, and they settle in the same cycle.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Active-low reset to all-ones configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration row address |
| cfg_wdata | input | 36 | Configuration row data |
| ded_in | input | 8 | Dedicated inputs, variables 0 to 7 |
| pin_in | input | 10 | Level seen on each bidirectional pin, variables 8 to 17 |
| pin_out | output | 10 | Value to drive on each pin |
| pin_oe | output | 10 | Drive enable for each pin |

## Verification
The configuration bits are the only internal state. A corrupted row shows at the ports in the same cycle that an input vector makes the affected term matter. Random configurations are set up so that terms fire often, and a wrong literal, sum connection, inversion bit or enable then shows up within a few vectors. A write that lands in the wrong row, or that wrongly accepts an out-of-range address, shows up on the first vector evaluated after it.

// File: rtl/pla_pkg.sv
package pla_pkg;

    localparam int unsigned PLA_DED_DEF   = 8;
    localparam int unsigned PLA_BIDIR_DEF = 10;
    localparam int unsigned PLA_LOGIC_DEF = 32;

    // One variable against its two literal links: a kept link must be satisfied.
    // Both links kept can never be satisfied, which disables the term.
    function automatic logic lit_pass(input logic v, input logic keep_t, input logic keep_c);
        return (v | ~keep_t) & (~v | ~keep_c);
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
    parameter int unsigned N_VAR   = 18,
    parameter int unsigned N_OUT   = 10,
    parameter int unsigned N_LOGIC = 32,
    parameter int unsigned ADDR_W  = 7,
    localparam int unsigned ROW_W    = 2 * N_VAR,
    localparam int unsigned N_AND    = N_LOGIC + N_OUT,
    localparam int unsigned OR_BASE  = N_AND,
    localparam int unsigned POL_ADDR = N_AND + N_LOGIC,
    localparam int unsigned AND_IW   = $clog2(N_AND),
    localparam int unsigned OR_IW    = $clog2(N_LOGIC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [ROW_W-1:0]         cfg_wdata,
    output logic [N_AND*ROW_W-1:0]   and_bits,
    output logic [N_LOGIC*N_OUT-1:0] or_bits,
    output logic [N_OUT-1:0]         pol_bits
);

    typedef struct packed {
        logic [N_AND-1:0][ROW_W-1:0]   andp;
        logic [N_LOGIC-1:0][N_OUT-1:0] orp;
        logic [N_OUT-1:0]              pol;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic [ADDR_W-1:0] or_off;

    always_comb begin
        cfg_d  = cfg_q;
        or_off = cfg_addr - ADDR_W'(OR_BASE);
        if (cfg_we) begin
            if (cfg_addr < ADDR_W'(N_AND)) begin
                cfg_d.andp[cfg_addr[AND_IW-1:0]] = cfg_wdata;
            end else if (cfg_addr < ADDR_W'(POL_ADDR)) begin
                cfg_d.orp[or_off[OR_IW-1:0]] = cfg_wdata[N_OUT-1:0];
            end else if (cfg_addr == ADDR_W'(POL_ADDR)) begin
                cfg_d.pol = cfg_wdata[N_OUT-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign and_bits = cfg_q.andp;
    assign or_bits  = cfg_q.orp;
    assign pol_bits = cfg_q.pol;

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int unsigned N_VAR  = 18,
    parameter int unsigned N_TERM = 42,
    localparam int unsigned ROW_W = 2 * N_VAR
) (
    input  logic [N_VAR-1:0]        vars,
    input  logic [N_TERM*ROW_W-1:0] and_bits,
    output logic [N_TERM-1:0]       terms
);

    logic [N_TERM-1:0][N_VAR-1:0] pass;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        for (genvar v = 0; v < N_VAR; v++) begin : g_var
            assign pass[t][v] = pla_pkg::lit_pass(vars[v],
                                                  and_bits[t*ROW_W + 2*v],
                                                  and_bits[t*ROW_W + 2*v + 1]);
        end
        assign terms[t] = &pass[t];
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int unsigned N_LOGIC = 32,
    parameter int unsigned N_OUT   = 10
) (
    input  logic [N_LOGIC-1:0]       lterms,
    input  logic [N_LOGIC*N_OUT-1:0] or_bits,
    input  logic [N_OUT-1:0]         pol_bits,
    output logic [N_OUT-1:0]         outs
);

    logic [N_OUT-1:0][N_LOGIC-1:0] hit;
    logic [N_OUT-1:0]              sums;

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        for (genvar p = 0; p < N_LOGIC; p++) begin : g_term
            assign hit[j][p] = lterms[p] & or_bits[p*N_OUT + j];
        end
        assign sums[j] = |hit[j];
        assign outs[j] = pol_bits[j] ? sums[j] : ~sums[j];
    end

endmodule

// File: rtl/pla_core.sv
module pla_core #(
    parameter int unsigned N_DED   = pla_pkg::PLA_DED_DEF,
    parameter int unsigned N_BIDIR = pla_pkg::PLA_BIDIR_DEF,
    parameter int unsigned N_LOGIC = pla_pkg::PLA_LOGIC_DEF,
    localparam int unsigned N_VAR  = N_DED + N_BIDIR,
    localparam int unsigned ROW_W  = 2 * N_VAR,
    localparam int unsigned N_AND  = N_LOGIC + N_BIDIR,
    localparam int unsigned N_ROWS = N_AND + N_LOGIC + 1,
    localparam int unsigned ADDR_W = $clog2(N_ROWS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [ROW_W-1:0]   cfg_wdata,
    input  logic [N_DED-1:0]   ded_in,
    input  logic [N_BIDIR-1:0] pin_in,
    output logic [N_BIDIR-1:0] pin_out,
    output logic [N_BIDIR-1:0] pin_oe
);

    logic [N_AND*ROW_W-1:0]     and_bits;
    logic [N_LOGIC*N_BIDIR-1:0] or_bits;
    logic [N_BIDIR-1:0]         pol_bits;
    logic [N_VAR-1:0]           vars;
    logic [N_AND-1:0]           terms;

    pla_cfg_store #(
        .N_VAR(N_VAR), .N_OUT(N_BIDIR), .N_LOGIC(N_LOGIC), .ADDR_W(ADDR_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .and_bits(and_bits), .or_bits(or_bits),
        .pol_bits(pol_bits)
    );

    // Pin levels follow the dedicated inputs in variable numbering.
    assign vars = {pin_in, ded_in};

    pla_and_plane #(.N_VAR(N_VAR), .N_TERM(N_AND)) u_and (
        .vars(vars), .and_bits(and_bits), .terms(terms)
    );

    pla_or_plane #(.N_LOGIC(N_LOGIC), .N_OUT(N_BIDIR)) u_or (
        .lterms(terms[N_LOGIC-1:0]), .or_bits(or_bits), .pol_bits(pol_bits),
        .outs(pin_out)
    );

    assign pin_oe = terms[N_AND-1:N_LOGIC];

endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk #(
    parameter int unsigned N_DED   = 8,
    parameter int unsigned N_BIDIR = 10,
    parameter int unsigned ADDR_W  = 7,
    parameter int unsigned N_ROWS  = 75
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [ADDR_W-1:0]  cfg_addr,
    input logic [N_DED-1:0]   ded_in,
    input logic [N_BIDIR-1:0] pin_in,
    input logic [N_BIDIR-1:0] pin_out,
    input logic [N_BIDIR-1:0] pin_oe
);

    // R1: leaving reset with nothing written, all pins idle and low
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));

    // R10: no write and steady inputs keep outputs steady
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_we) && $stable(ded_in) && $stable(pin_in))
        |-> ($stable(pin_out) && $stable(pin_oe)));

    // R9: write beyond the map leaves outputs untouched
    a_r9_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we && cfg_addr >= ADDR_W'(N_ROWS)) && $stable(ded_in) && $stable(pin_in))
        |-> ($stable(pin_out) && $stable(pin_oe)));

    // R2: outputs are always defined once out of reset
    a_r2_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({pin_out, pin_oe}));

endmodule

bind pla_core pla_core_chk #(
    .N_DED(N_DED), .N_BIDIR(N_BIDIR), .ADDR_W(ADDR_W), .N_ROWS(N_ROWS)
) u_chk (.*);

// File: tb/pla_core_bench.sv
module pla_core_bench;

    localparam int NV = 18, NO = 10, NL = 32, NA = 42, RW = 36;
    localparam int OR_BASE = 42, POL_ADDR = 74;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [6:0]    cfg_addr = '0;
    logic [RW-1:0] cfg_wdata = '0;
    logic [7:0]    ded_in = '0;
    logic [NO-1:0] pin_in = '0;
    logic [NO-1:0] pin_out, pin_oe;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    logic [RW-1:0] m_and [NA];
    logic [NO-1:0] m_or  [NL];
    logic [NO-1:0] m_pol;

    always #2.5 clk = ~clk;

    pla_core u_pla_core (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ded_in(ded_in), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic term_val(int t, logic [7:0] d, logic [NO-1:0] p);
        logic [NV-1:0] x;
        logic r;
        x = {p, d};
        r = 1'b1;
        for (int v = 0; v < NV; v++) begin
            if (m_and[t][2*v] && !x[v]) r = 1'b0;
            if (m_and[t][2*v+1] && x[v]) r = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [2*NO-1:0] expect_io(logic [7:0] d, logic [NO-1:0] p);
        logic [NO-1:0] s, oe;
        s = '0;
        for (int t = 0; t < NL; t++)
            if (term_val(t, d, p)) s |= m_or[t];
        for (int j = 0; j < NO; j++) oe[j] = term_val(NL + j, d, p);
        return {oe, (s & m_pol) | (~s & ~m_pol)};
    endfunction

    task automatic chk(string tag, logic [2*NO-1:0] got, logic [2*NO-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NA; i++) m_and[i] = '1;
        for (int i = 0; i < NL; i++) m_or[i] = '1;
        m_pol = '1;
    endtask

    task automatic wr(int a, logic [RW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < NA) m_and[a] = d;
        else if (a < POL_ADDR) m_or[a - OR_BASE] = d[NO-1:0];
        else if (a == POL_ADDR) m_pol = d[NO-1:0];
    endtask

    task automatic apply(string tag, logic [7:0] d, logic [NO-1:0] p);
        @(negedge clk);
        ded_in = d; pin_in = p;
        #1;
        chk(tag, {pin_oe, pin_out}, expect_io(d, p));
    endtask

    function automatic logic [RW-1:0] rand_row();
        logic [RW-1:0] r;
        r = '0;
        for (int v = 0; v < NV; v++) begin
            int k;
            k = int'($urandom % 24);
            if (k == 0) r[2*v] = 1'b1;
            else if (k == 1) r[2*v+1] = 1'b1;
            else if (k == 2 && ($urandom % 8) == 0) r[2*v +: 2] = 2'b11;
        end
        return r;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4817));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 reset", {pin_oe, pin_out}, '0);
        apply("R1 reset vector", 8'hA5, 10'h3C3);
        chk("R1 reset explicit", {pin_oe, pin_out}, '0);

        // R2 R3 R5: term 0 = ded_in[0], routed to output 3 only
        wr(0, 36'h1);
        wr(OR_BASE + 0, 36'h008);
        apply("R3 term true", 8'h01, '0);
        chk("R5 single route", {pin_oe, pin_out}, {10'h0, 10'h008});
        apply("R3 term false", 8'h00, '0);
        chk("R3 literal false", {pin_oe, pin_out}, '0);
        // R3: inverse literal of ded_in[2]
        wr(0, 36'h20);
        apply("R3 inverse lit", 8'h00, '0);
        chk("R3 inverse explicit", {pin_oe, pin_out}, {10'h0, 10'h008});

        // R4: both literals kept disables term
        wr(0, 36'h3);
        apply("R4 conflict d0=1", 8'h01, '0);
        apply("R4 conflict d0=0", 8'h00, '0);
        chk("R4 conflict explicit", {pin_oe, pin_out}, '0);

        // R5: one term feeding every output
        wr(0, 36'h0);
        wr(OR_BASE + 0, 36'h3FF);
        apply("R5 shared all", 8'h00, '0);
        chk("R5 shared explicit", {pin_oe, pin_out}, {10'h0, 10'h3FF});

        // R6: inversion on output 3 with term off
        wr(0, 36'h3);
        wr(POL_ADDR, 36'h3F7);
        apply("R6 invert", 8'h00, '0);
        chk("R6 invert explicit", {pin_oe, pin_out}, {10'h0, 10'h008});

        // R7: enable term 2 always true; R8: enable 1 follows pin_in[0]
        wr(NL + 2, 36'h0);
        wr(NL + 1, 36'h1 << 16);
        apply("R7 enable const", 8'h00, 10'h000);
        chk("R7 enable explicit", pin_oe, 10'h004);
        apply("R8 feedback on", 8'h00, 10'h001);
        chk("R8 feedback explicit", pin_oe, 10'h006);

        // R9: out-of-range write and upper data bits ignored
        wr(100, '1);
        apply("R9 bad addr", 8'h00, 10'h001);
        wr(POL_ADDR, 36'hFFFFFF3F7);
        apply("R9 upper bits", 8'h00, 10'h000);

        // R10: input-only changes settle without a clock edge
        #1 ded_in = 8'hFF; pin_in = 10'h001;
        #1 chk("R10 comb settle", {pin_oe, pin_out}, expect_io(8'hFF, 10'h001));

        // Random configurations against the model (R2 R3 R5 R6 R7 R8)
        for (int c = 0; c < 40; c++) begin
            for (int r = 0; r < NA; r++) wr(r, rand_row());
            for (int r = 0; r < NL; r++) wr(OR_BASE + r, {26'h0, 10'($urandom)});
            wr(POL_ADDR, {26'h0, 10'($urandom)});
            for (int k = 0; k < 25; k++)
                apply("R5 random", 8'($urandom), 10'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule